// File: doc/BRIEF.md
# Interlock Pipeline Hazard Controller

This block decides, every cycle, whether a five-stage in-order pipeline (fetch, decode, execute, memory, writeback) may advance. The pipeline has no forwarding paths. Registers are read during decode and written only at writeback. So a decode-stage instruction whose source register is still being produced by any of the three later stages has to wait. The controller compares both decode-stage source indices against the destination of every later stage that is writing a register. On a match it freezes the program counter and the fetch/decode register, and it inserts an empty slot into the decode/execute register.

Control flow follows a predict-not-taken scheme. Branches and jumps are resolved in execute. When a resolved branch turns out taken, the two younger instructions already fetched are on the wrong path. The instruction in fetch is dropped by clearing the fetch/decode register, and the instruction in decode is dropped by making the decode/execute register empty. At the same time the program counter loads the branch target. A redirect always wins over a data-dependency wait, because the waiting instruction is itself being discarded.

The block is purely combinational. All register updates are performed by the surrounding pipeline according to these outputs. An empty slot means an instruction word of all zeros with its register write-enable and memory write-enable cleared.

Top module: `hazard_interlock_ctrl`

## Requirements
- R1: When the decode source index `rs_a_i` is nonzero and equals the destination of any of execute, memory or writeback whose write-enable is set, the controller requests a stall.
- R2: The same test applies to source index `rs_b_i`, and a stall is requested if either source matches.
- R3: A source index of zero never causes a stall, even when a later stage writes register zero.
- R4: A stage whose write-enable is low never causes a stall, even when its destination matches a source.
- R5: During a stall with no redirect, `pc_hold_o`, `ifid_hold_o` and `idex_bubble_o` are all 1, and `ifid_flush_o` and `pc_redirect_o` are 0.
- R6: When `br_resolved_i` and `br_taken_i` are both 1, `pc_redirect_o`, `ifid_flush_o` and `idex_bubble_o` are 1.
- R7: When a redirect and a stall condition coincide, the redirect takes priority: `pc_hold_o` and `ifid_hold_o` are 0, and the three redirect outputs are 1.
- R8: A branch resolved as not taken (`br_resolved_i`=1, `br_taken_i`=0) produces no redirect and no flush.
- R9: `br_taken_i` is ignored while `br_resolved_i` is 0.
- R10: With no dependency and no redirect, all five outputs are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| rs_a_i | input | REG_IDX_W | First source register index of the decode-stage instruction |
| rs_b_i | input | REG_IDX_W | Second source register index of the decode-stage instruction |
| ex_rd_i | input | REG_IDX_W | Destination index of the execute-stage instruction |
| ex_we_i | input | 1 | Register write-enable of the execute-stage instruction |
| mem_rd_i | input | REG_IDX_W | Destination index of the memory-stage instruction |
| mem_we_i | input | 1 | Register write-enable of the memory-stage instruction |
| wb_rd_i | input | REG_IDX_W | Destination index of the writeback-stage instruction |
| wb_we_i | input | 1 | Register write-enable of the writeback-stage instruction |
| br_resolved_i | input | 1 | A branch or jump in execute has its outcome this cycle |
| br_taken_i | input | 1 | The resolved branch or jump is taken |
| pc_hold_o | output | 1 | Keep the program counter unchanged |
| ifid_hold_o | output | 1 | Keep the fetch/decode register unchanged |
| idex_bubble_o | output | 1 | Load an empty slot into the decode/execute register |
| ifid_flush_o | output | 1 | Load an empty slot into the fetch/decode register |
| pc_redirect_o | output | 1 | Load the branch target into the program counter |

## Verification
A data-dependency stall and a taken-branch redirect can occur in the same cycle. This happens when a taken branch sits in execute while the decode instruction depends on a register that is still in flight. The bench provokes this by setting a source to match a writing stage while it asserts both branch flags. It judges the result by requiring both holds to be released and the flush, bubble and redirect outputs to be set. It also checks the opposite case: the same dependency with the branch not taken must still produce an ordinary stall.

// File: rtl/hzd_pkg.sv
package hzd_pkg;
  // Stages that can still hold a pending register write
  typedef enum logic [1:0] {
    STG_EX  = 2'd0,
    STG_MEM = 2'd1,
    STG_WB  = 2'd2
  } wr_stage_e;

  localparam int unsigned NUM_WR_STAGES = 3;
  localparam int unsigned NUM_SRC       = 2;

  typedef struct packed {
    logic hold_pc;
    logic hold_ifid;
    logic bubble_idex;
    logic flush_ifid;
    logic redirect_pc;
  } pipe_ctrl_t;
endpackage

// File: rtl/hzd_src_match.sv
module hzd_src_match #(
  parameter int unsigned IDX_W = 5,
  parameter int unsigned N_DST = 3
) (
  input  logic [IDX_W-1:0]            src_i,
  input  logic [N_DST-1:0][IDX_W-1:0] dst_i,
  input  logic [N_DST-1:0]            dst_we_i,
  output logic [N_DST-1:0]            hit_vec_o,
  output logic                        hit_o
);
  logic src_live;
  assign src_live = (src_i != '0);

  for (genvar g = 0; g < N_DST; g++) begin : g_dst
    assign hit_vec_o[g] = src_live && dst_we_i[g] && (dst_i[g] == src_i);
  end

  assign hit_o = |hit_vec_o;

  always_comb begin
    if (!$isunknown({src_i, dst_i, dst_we_i})) begin
      assert_zero_src_quiet_R3: assert (!(src_i == '0 && hit_o))
        else $error("zero source flagged");
      assert_we_gates_hit_R4: assert ((hit_vec_o & ~dst_we_i) == '0)
        else $error("hit from non-writing stage");
    end
  end
endmodule

// File: rtl/hzd_raw_detect.sv
module hzd_raw_detect #(
  parameter int unsigned IDX_W = 5,
  parameter int unsigned N_SRC = 2,
  parameter int unsigned N_DST = 3
) (
  input  logic [N_SRC-1:0][IDX_W-1:0] src_i,
  input  logic [N_DST-1:0][IDX_W-1:0] dst_i,
  input  logic [N_DST-1:0]            dst_we_i,
  output logic [N_SRC-1:0]            src_hit_o,
  output logic                        raw_o
);
  for (genvar s = 0; s < N_SRC; s++) begin : g_src
    logic [N_DST-1:0] hv;
    hzd_src_match #(.IDX_W(IDX_W), .N_DST(N_DST)) u_match (
      .src_i     (src_i[s]),
      .dst_i     (dst_i),
      .dst_we_i  (dst_we_i),
      .hit_vec_o (hv),
      .hit_o     (src_hit_o[s])
    );
  end

  assign raw_o = |src_hit_o;
endmodule

// File: rtl/hzd_ctrl.sv
module hzd_ctrl
  import hzd_pkg::*;
(
  input  logic       raw_i,
  input  logic       br_resolved_i,
  input  logic       br_taken_i,
  output pipe_ctrl_t ctrl_o
);
  logic redirect;
  logic stall;

  assign redirect = br_resolved_i && br_taken_i;
  // redirect discards the waiting instruction, so it overrides the hold
  assign stall    = raw_i && !redirect;

  always_comb begin
    ctrl_o             = '0;
    ctrl_o.hold_pc     = stall;
    ctrl_o.hold_ifid   = stall;
    ctrl_o.bubble_idex = stall || redirect;
    ctrl_o.flush_ifid  = redirect;
    ctrl_o.redirect_pc = redirect;
  end

  always_comb begin
    if (!$isunknown({raw_i, br_resolved_i, br_taken_i})) begin
      assert_hold_pair_R5: assert (ctrl_o.hold_pc == ctrl_o.hold_ifid)
        else $error("holds disagree");
      assert_hold_needs_bubble_R5: assert (!ctrl_o.hold_pc || ctrl_o.bubble_idex)
        else $error("hold without bubble");
      assert_flush_beats_hold_R7: assert (!(ctrl_o.redirect_pc && ctrl_o.hold_pc))
        else $error("hold during redirect");
    end
  end
endmodule

// File: rtl/hazard_interlock_ctrl.sv
module hazard_interlock_ctrl
  import hzd_pkg::*;
#(
  parameter int unsigned REG_IDX_W = 5
) (
  input  logic [REG_IDX_W-1:0] rs_a_i,
  input  logic [REG_IDX_W-1:0] rs_b_i,
  input  logic [REG_IDX_W-1:0] ex_rd_i,
  input  logic                 ex_we_i,
  input  logic [REG_IDX_W-1:0] mem_rd_i,
  input  logic                 mem_we_i,
  input  logic [REG_IDX_W-1:0] wb_rd_i,
  input  logic                 wb_we_i,
  input  logic                 br_resolved_i,
  input  logic                 br_taken_i,
  output logic                 pc_hold_o,
  output logic                 ifid_hold_o,
  output logic                 idex_bubble_o,
  output logic                 ifid_flush_o,
  output logic                 pc_redirect_o
);
  logic [NUM_SRC-1:0][REG_IDX_W-1:0]       srcs;
  logic [NUM_WR_STAGES-1:0][REG_IDX_W-1:0] dsts;
  logic [NUM_WR_STAGES-1:0]                dst_we;
  logic [NUM_SRC-1:0]                      src_hit;
  logic                                    raw;
  pipe_ctrl_t                              ctrl;

  assign srcs[0] = rs_a_i;
  assign srcs[1] = rs_b_i;

  assign dsts[STG_EX]    = ex_rd_i;
  assign dsts[STG_MEM]   = mem_rd_i;
  assign dsts[STG_WB]    = wb_rd_i;
  assign dst_we[STG_EX]  = ex_we_i;
  assign dst_we[STG_MEM] = mem_we_i;
  assign dst_we[STG_WB]  = wb_we_i;

  hzd_raw_detect #(
    .IDX_W (REG_IDX_W),
    .N_SRC (NUM_SRC),
    .N_DST (NUM_WR_STAGES)
  ) u_raw (
    .src_i     (srcs),
    .dst_i     (dsts),
    .dst_we_i  (dst_we),
    .src_hit_o (src_hit),
    .raw_o     (raw)
  );

  hzd_ctrl u_ctrl (
    .raw_i         (raw),
    .br_resolved_i (br_resolved_i),
    .br_taken_i    (br_taken_i),
    .ctrl_o        (ctrl)
  );

  assign pc_hold_o     = ctrl.hold_pc;
  assign ifid_hold_o   = ctrl.hold_ifid;
  assign idex_bubble_o = ctrl.bubble_idex;
  assign ifid_flush_o  = ctrl.flush_ifid;
  assign pc_redirect_o = ctrl.redirect_pc;

  always_comb begin
    if (!$isunknown({br_resolved_i, br_taken_i, pc_redirect_o, ifid_flush_o})) begin
      assert_no_redirect_unresolved_R9: assert (br_resolved_i || !pc_redirect_o)
        else $error("redirect without resolution");
      assert_no_flush_not_taken_R8: assert (br_taken_i || !ifid_flush_o)
        else $error("flush on not-taken branch");
      assert_redirect_flush_pair_R6: assert (pc_redirect_o == ifid_flush_o)
        else $error("redirect and flush disagree");
    end
  end
endmodule

// File: tb/hazard_interlock_ctrl_bench.sv
module hazard_interlock_ctrl_bench;
  localparam int unsigned W = 5;

  logic clk = 1'b0;
  always #10 clk = ~clk;  // 50 MHz

  logic [W-1:0] rs_a, rs_b, ex_rd, mem_rd, wb_rd;
  logic ex_we, mem_we, wb_we, br_res, br_tk;
  logic pc_hold, ifid_hold, idex_bubble, ifid_flush, pc_redirect;

  int checks = 0;
  int failures = 0;
  bit done = 0;

  hazard_interlock_ctrl #(.REG_IDX_W(W)) u_hazard_interlock_ctrl (
    .rs_a_i (rs_a), .rs_b_i (rs_b),
    .ex_rd_i (ex_rd), .ex_we_i (ex_we),
    .mem_rd_i (mem_rd), .mem_we_i (mem_we),
    .wb_rd_i (wb_rd), .wb_we_i (wb_we),
    .br_resolved_i (br_res), .br_taken_i (br_tk),
    .pc_hold_o (pc_hold), .ifid_hold_o (ifid_hold),
    .idex_bubble_o (idex_bubble), .ifid_flush_o (ifid_flush),
    .pc_redirect_o (pc_redirect)
  );

  task automatic idle();
    rs_a = '0; rs_b = '0; ex_rd = '0; mem_rd = '0; wb_rd = '0;
    ex_we = 0; mem_we = 0; wb_we = 0; br_res = 0; br_tk = 0;
  endtask

  // outputs packed {pc_hold, ifid_hold, idex_bubble, ifid_flush, pc_redirect}
  task automatic expect_out(string req, logic [4:0] exp);
    logic [4:0] act;
    @(posedge clk); #5;
    act = {pc_hold, ifid_hold, idex_bubble, ifid_flush, pc_redirect};
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s actual=%b expected=%b", req, act, exp);
    end
  endtask

  localparam logic [4:0] O_NONE  = 5'b00000;
  localparam logic [4:0] O_STALL = 5'b11100;
  localparam logic [4:0] O_REDIR = 5'b00111;

  task automatic t_quiet_R10();
    idle(); ex_rd = 5'd3; mem_rd = 5'd4; wb_rd = 5'd5;
    ex_we = 1; mem_we = 1; wb_we = 1; rs_a = 5'd6; rs_b = 5'd7;
    expect_out("R10 idle", O_NONE);
  endtask

  task automatic t_src_a_R1();
    for (int s = 0; s < 3; s++) begin
      idle(); rs_a = 5'd9; rs_b = 5'd1;
      case (s)
        0: begin ex_rd = 5'd9; ex_we = 1; end
        1: begin mem_rd = 5'd9; mem_we = 1; end
        default: begin wb_rd = 5'd9; wb_we = 1; end
      endcase
      expect_out("R1 src A vs stage", O_STALL);
    end
  endtask

  task automatic t_src_b_R2();
    for (int s = 0; s < 3; s++) begin
      idle(); rs_a = 5'd2; rs_b = 5'd31;
      case (s)
        0: begin ex_rd = 5'd31; ex_we = 1; end
        1: begin mem_rd = 5'd31; mem_we = 1; end
        default: begin wb_rd = 5'd31; wb_we = 1; end
      endcase
      expect_out("R2 src B vs stage", O_STALL);
    end
  endtask

  task automatic t_zero_R3();
    idle(); ex_we = 1; mem_we = 1; wb_we = 1;
    expect_out("R3 reg zero", O_NONE);
  endtask

  task automatic t_we_low_R4();
    idle(); rs_a = 5'd8; rs_b = 5'd8; ex_rd = 5'd8; mem_rd = 5'd8; wb_rd = 5'd8;
    expect_out("R4 we low", O_NONE);
    mem_we = 1;
    expect_out("R4 only mem writes", O_STALL);
  endtask

  task automatic t_stall_R5();
    idle(); rs_a = 5'd12; rs_b = 5'd12; ex_rd = 5'd12; ex_we = 1;
    mem_rd = 5'd12; mem_we = 1;
    expect_out("R5 stall outputs", O_STALL);
  endtask

  task automatic t_redirect_R6();
    idle(); br_res = 1; br_tk = 1;
    expect_out("R6 taken redirect", O_REDIR);
  endtask

  task automatic t_collide_R7();
    idle(); rs_a = 5'd10; ex_rd = 5'd10; ex_we = 1; br_res = 1; br_tk = 1;
    expect_out("R7 redirect over stall", O_REDIR);
    br_tk = 0;
    expect_out("R7 same dependency not taken", O_STALL);
  endtask

  task automatic t_not_taken_R8();
    idle(); br_res = 1; br_tk = 0;
    expect_out("R8 not taken", O_NONE);
  endtask

  task automatic t_unresolved_R9();
    idle(); br_res = 0; br_tk = 1;
    expect_out("R9 taken unresolved", O_NONE);
    rs_b = 5'd5; wb_rd = 5'd5; wb_we = 1;
    expect_out("R9 unresolved with stall", O_STALL);
  endtask

  initial begin
    idle();
    @(negedge clk);
    t_quiet_R10();
    t_src_a_R1();
    t_src_b_R2();
    t_zero_R3();
    t_we_low_R4();
    t_stall_R5();
    t_redirect_R6();
    t_collide_R7();
    t_not_taken_R8();
    t_unresolved_R9();
    done = 1;
  end

  initial begin
    fork
      wait (done);
      begin
        repeat (5000) @(posedge clk);
        checks++; failures++;
        $display("FAIL watchdog actual=timeout expected=done");
      end
    join_any
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule